// File: doc/BRIEF.md
# Channel to Divider Code Encoder

This block turns a front-panel channel choice into the 9-bit division ratio N that programs the feedback divider of a single-loop frequency synthesizer. The legal channel plan is irregular. Five frequencies in the nominal band are never assigned. Channels 23 to 25 are assigned out of sequence. The encoder therefore computes the ratio from the channel number by arithmetic, applies a correction for each skipped step and swaps the three out-of-order channels, rather than holding a lookup table.

Five bands of 40 channels sit side by side: two below the nominal band, the nominal band itself and two above it. Each band step moves N by 45, and N falls as frequency rises. A selection that cannot be programmed raises a misprogram flag. A build-time parameter then chooses the reaction: block the transmitter, or substitute the fixed emergency channel 9 or channel 19 of the nominal band. All outputs come from one register stage.

Top module: `chsel_ncode_enc`

## Requirements
- R1: In the nominal band (band code 2), channel 1 gives N = 330 and channel 40 gives N = 286. N never rises as the channel number rises, apart from the swap described in R3.
- R2: In the nominal band, a legal selection never yields N = 327, 322, 317, 312 or 307. These are the skipped steps after channels 3, 7, 11, 15 and 19.
- R3: In the nominal band, channels 23, 24 and 25 give N = 301, 303 and 302.
- R4: `n_code` is plain binary, with bit i weighted 2^i (bit 0 is the LSB). Channel 1 in the nominal band therefore sets exactly bits 8, 6, 3 and 1.
- R5: Band codes 0 to 4 stand for -80, -40, nominal, +40 and +80 channels. N equals the nominal-band value plus (2 - band) * 45.
- R6: A legal selection gives `code_valid` = 1, `misprog` = 0 and `tx_inhibit` = 0.
- R7: These selections are illegal: channel 0, any channel above 40, and any band code above 4.
- R8: With FALLBACK = FB_INHIBIT, an illegal selection gives `misprog` = 1, `tx_inhibit` = 1, `code_valid` = 0 and `n_code` = 0.
- R9: With FALLBACK = FB_CH9, an illegal selection gives `n_code` = 320 (channel 9, nominal band), with `misprog` = 1, `code_valid` = 1 and `tx_inhibit` = 0.
- R10: With FALLBACK = FB_CH19, an illegal selection gives `n_code` = 308 (channel 19, nominal band), with the same flags as in R9.
- R11: The outputs follow the inputs with exactly one clock of latency: a change of input shows up after the next rising edge and not before.
- R12: While `rst` is high on a rising edge, the outputs become `n_code` = 0, `code_valid` = 0, `misprog` = 0 and `tx_inhibit` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_sel | input | 6 | Selected channel number, 1 to 40 when legal |
| band_sel | input | 3 | Band code, 0 to 4 when legal, 2 = nominal |
| n_code | output | 9 | Registered divide-by-N value, binary |
| code_valid | output | 1 | `n_code` may be used to program the divider |
| misprog | output | 1 | The selection on the previous edge was illegal |
| tx_inhibit | output | 1 | Transmitter must be blocked |

## Verification
The assertions assume that `chan_sel` and `band_sel` are stable around each rising edge. They also assume that one clock edge is enough to see the result of the inputs present at the previous edge. Neither input is assumed to stay legal: the properties keep one registered copy of the legality and of the band, so illegal values are part of the checked space. The stimulus changes inputs only on falling edges. It sweeps all 512 combinations of the two input fields, so every illegal code and every band is reached, and it includes a reset pulse in the middle of the run.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    typedef enum logic [1:0] {
        FB_INHIBIT = 2'd0,
        FB_CH9     = 2'd1,
        FB_CH19    = 2'd2
    } fallback_e;

    localparam int CH_W      = 6;
    localparam int BAND_W    = 3;
    localparam int N_W       = 9;
    localparam int NUM_CH    = 40;
    localparam int NUM_BANDS = 5;
    localparam int NOM_BAND  = 2;
    localparam int BAND_STEP = 45;
    localparam int TOP_CODE  = 330;   // channel 1, nominal band
    localparam int GAP_COUNT = 5;     // skipped steps in the channel plan
    localparam int GAP_FIRST = 4;     // first channel past a skipped step
    localparam int GAP_PITCH = 4;     // channels between skipped steps
    localparam int SWAP_BASE = 23;    // first of three rotated channels

    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [BAND_W-1:0] band_t;
    typedef logic [N_W-1:0]    code_t;

    typedef struct packed {
        code_t code;
        logic  valid;
        logic  misprog;
        logic  inhibit;
    } enc_out_t;

    function automatic int emerg_chan(fallback_e mode);
        return (mode == FB_CH19) ? 19 : 9;
    endfunction

endpackage

// File: rtl/chsel_legal_chk.sv
module chsel_legal_chk
    import chsel_pkg::*;
(
    input  chan_t chan,
    input  band_t band,
    output logic  legal
);
    localparam chan_t LAST_CH   = chan_t'(NUM_CH);
    localparam band_t LAST_BAND = band_t'(NUM_BANDS - 1);

    assign legal = (chan != '0) && (chan <= LAST_CH) && (band <= LAST_BAND);
endmodule

// File: rtl/chsel_nominal_map.sv
module chsel_nominal_map
    import chsel_pkg::*;
(
    input  chan_t chan,
    output code_t code
);
    localparam int CNT_W = $clog2(GAP_COUNT + 1);

    chan_t              ch_eff;
    logic [GAP_COUNT-1:0] gap_hit;
    logic [CNT_W-1:0]   gap_total;

    // channels 23..25 take the slots of 25, 23, 24
    always_comb begin
        ch_eff = chan;
        if (chan == chan_t'(SWAP_BASE))
            ch_eff = chan_t'(SWAP_BASE + 2);
        else if (chan == chan_t'(SWAP_BASE + 1))
            ch_eff = chan_t'(SWAP_BASE);
        else if (chan == chan_t'(SWAP_BASE + 2))
            ch_eff = chan_t'(SWAP_BASE + 1);
    end

    for (genvar g = 0; g < GAP_COUNT; g++) begin : g_gap
        assign gap_hit[g] = (ch_eff >= chan_t'(GAP_FIRST + GAP_PITCH * g));
    end

    always_comb begin
        gap_total = '0;
        for (int g = 0; g < GAP_COUNT; g++)
            gap_total = gap_total + CNT_W'(gap_hit[g]);
    end

    assign code = code_t'(TOP_CODE + 1) - code_t'(ch_eff) - code_t'(gap_total);
endmodule

// File: rtl/chsel_band_adjust.sv
module chsel_band_adjust
    import chsel_pkg::*;
(
    input  code_t nom,
    input  band_t band,
    output code_t code
);
    code_t ofs_tab [NUM_BANDS];

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_ofs
        if (b <= NOM_BAND) begin : g_low
            assign ofs_tab[b] = code_t'((NOM_BAND - b) * BAND_STEP);
        end else begin : g_high
            assign ofs_tab[b] = code_t'((b - NOM_BAND) * BAND_STEP);
        end
    end

    always_comb begin
        code = nom;
        for (int b = 0; b < NUM_BANDS; b++) begin
            if (band == band_t'(b)) begin
                if (b <= NOM_BAND) code = nom + ofs_tab[b];
                else               code = nom - ofs_tab[b];
            end
        end
    end
endmodule

// File: rtl/chsel_ncode_enc.sv
module chsel_ncode_enc
    import chsel_pkg::*;
#(
    parameter fallback_e FALLBACK = FB_CH9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [BAND_W-1:0] band_sel,
    output logic [N_W-1:0]    n_code,
    output logic              code_valid,
    output logic              misprog,
    output logic              tx_inhibit
);
    localparam enc_out_t RESET_OUT = '{code: '0, valid: 1'b0, misprog: 1'b0, inhibit: 1'b1};

    logic     legal;
    code_t    nom_code;
    code_t    band_code;
    code_t    emerg_code;
    enc_out_t nxt;
    enc_out_t q;

    chsel_legal_chk u_legal (
        .chan  (chan_sel),
        .band  (band_sel),
        .legal (legal)
    );

    chsel_nominal_map u_nominal (
        .chan (chan_sel),
        .code (nom_code)
    );

    chsel_band_adjust u_band (
        .nom  (nom_code),
        .band (band_sel),
        .code (band_code)
    );

    if (FALLBACK == FB_INHIBIT) begin : g_no_emerg
        assign emerg_code = '0;
    end else begin : g_emerg
        localparam chan_t EMERG_CH = chan_t'(emerg_chan(FALLBACK));
        chsel_nominal_map u_emerg (
            .chan (EMERG_CH),
            .code (emerg_code)
        );
    end

    always_comb begin
        if (legal)
            nxt = '{code: band_code, valid: 1'b1, misprog: 1'b0, inhibit: 1'b0};
        else if (FALLBACK == FB_INHIBIT)
            nxt = '{code: '0, valid: 1'b0, misprog: 1'b1, inhibit: 1'b1};
        else
            nxt = '{code: emerg_code, valid: 1'b1, misprog: 1'b1, inhibit: 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RESET_OUT;
        else     q <= nxt;
    end

    assign n_code     = q.code;
    assign code_valid = q.valid;
    assign misprog    = q.misprog;
    assign tx_inhibit = q.inhibit;
endmodule

// File: rtl/chsel_ncode_chk.sv
module chsel_ncode_chk
    import chsel_pkg::*;
#(
    parameter fallback_e FALLBACK = FB_CH9
) (
    input logic              clk,
    input logic              rst,
    input logic [CH_W-1:0]   chan_sel,
    input logic [BAND_W-1:0] band_sel,
    input logic [N_W-1:0]    n_code,
    input logic              code_valid,
    input logic              misprog,
    input logic              tx_inhibit
);
    logic prev_rst;
    logic prev_legal;
    logic prev_nominal;

    always_ff @(posedge clk) begin
        prev_rst     <= rst;
        prev_legal   <= (chan_sel >= 6'd1) && (chan_sel <= 6'd40) && (band_sel <= 3'd4);
        prev_nominal <= (band_sel == 3'd2);
    end

    assert_legal_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (!prev_rst && prev_legal) |-> (code_valid && !misprog && !tx_inhibit));

    assert_nominal_span_R1: assert property (@(posedge clk) disable iff (rst)
        (!prev_rst && prev_legal && prev_nominal) |-> (n_code >= 9'd286 && n_code <= 9'd330));

    assert_no_gap_code_R2: assert property (@(posedge clk) disable iff (rst)
        (!prev_rst && prev_legal && prev_nominal) |->
        (n_code != 9'd327 && n_code != 9'd322 && n_code != 9'd317 &&
         n_code != 9'd312 && n_code != 9'd307));

    assert_inhibit_blocks_valid_R8: assert property (@(posedge clk) disable iff (rst)
        tx_inhibit |-> !code_valid);

    if (FALLBACK == FB_INHIBIT) begin : g_inh
        assert_illegal_inhibit_R8: assert property (@(posedge clk) disable iff (rst)
            (!prev_rst && !prev_legal) |->
            (tx_inhibit && misprog && !code_valid && n_code == 9'd0));
    end else if (FALLBACK == FB_CH9) begin : g_c9
        assert_illegal_ch9_R9: assert property (@(posedge clk) disable iff (rst)
            (!prev_rst && !prev_legal) |->
            (misprog && code_valid && !tx_inhibit && n_code == 9'd320));
    end else begin : g_c19
        assert_illegal_ch19_R10: assert property (@(posedge clk) disable iff (rst)
            (!prev_rst && !prev_legal) |->
            (misprog && code_valid && !tx_inhibit && n_code == 9'd308));
    end
endmodule

bind chsel_ncode_enc chsel_ncode_chk #(.FALLBACK(FALLBACK)) u_ncode_chk (
    .clk        (clk),
    .rst        (rst),
    .chan_sel   (chan_sel),
    .band_sel   (band_sel),
    .n_code     (n_code),
    .code_valid (code_valid),
    .misprog    (misprog),
    .tx_inhibit (tx_inhibit)
);

// File: tb/test_chsel_ncode_enc.sv
module test_chsel_ncode_enc;
    import chsel_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] chan_sel = 6'd1;
    logic [2:0] band_sel = 3'd2;

    always #4 clk = ~clk;   // 125 MHz

    logic [8:0] nc_inh, nc_c9, nc_c19;
    logic       v_inh, v_c9, v_c19;
    logic       m_inh, m_c9, m_c19;
    logic       i_inh, i_c9, i_c19;

    chsel_ncode_enc #(.FALLBACK(FB_CH9)) i_chsel_ncode_enc (
        .clk(clk), .rst(rst), .chan_sel(chan_sel), .band_sel(band_sel),
        .n_code(nc_c9), .code_valid(v_c9), .misprog(m_c9), .tx_inhibit(i_c9));

    chsel_ncode_enc #(.FALLBACK(FB_INHIBIT)) i_chsel_ncode_enc_inh (
        .clk(clk), .rst(rst), .chan_sel(chan_sel), .band_sel(band_sel),
        .n_code(nc_inh), .code_valid(v_inh), .misprog(m_inh), .tx_inhibit(i_inh));

    chsel_ncode_enc #(.FALLBACK(FB_CH19)) i_chsel_ncode_enc_c19 (
        .clk(clk), .rst(rst), .chan_sel(chan_sel), .band_sel(band_sel),
        .n_code(nc_c19), .code_valid(v_c19), .misprog(m_c19), .tx_inhibit(i_c19));

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // legal frequencies in kHz, nominal band, in ascending order
    int freqs[$];

    function automatic int ref_nom(int ch);
        int idx = ch - 1;
        if (ch == 23) idx = 24;
        else if (ch == 24) idx = 22;
        else if (ch == 25) idx = 23;
        return 330 - (freqs[idx] - 26965) / 10;
    endfunction

    function automatic bit is_illegal(int ch, int band);
        return (ch < 1) || (ch > 40) || (band > 4);
    endfunction

    // packed view: code<<3 | valid<<2 | misprog<<1 | inhibit; mode 0=inhibit,1=ch9,2=ch19
    function automatic int dut_word(int mode);
        case (mode)
            0:       return (int'(nc_inh) << 3) | (int'(v_inh) << 2) | (int'(m_inh) << 1) | int'(i_inh);
            1:       return (int'(nc_c9)  << 3) | (int'(v_c9)  << 2) | (int'(m_c9)  << 1) | int'(i_c9);
            default: return (int'(nc_c19) << 3) | (int'(v_c19) << 2) | (int'(m_c19) << 1) | int'(i_c19);
        endcase
    endfunction

    function automatic int ref_word(int mode, bit r, int ch, int band);
        if (r) return 1;
        if (is_illegal(ch, band)) begin
            if (mode == 0) return 3;
            return ((mode == 1 ? ref_nom(9) : ref_nom(19)) << 3) | 6;
        end
        return ((ref_nom(ch) + (2 - band) * 45) << 3) | 4;
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // cycle model: expectation captured at each rising edge
    int exp_w[3];
    bit exp_live = 0;
    bit exp_rst;
    bit exp_ill;
    int exp_band;

    always @(posedge clk) begin
        for (int m = 0; m < 3; m++)
            exp_w[m] = ref_word(m, rst, int'(chan_sel), int'(band_sel));
        exp_rst  = rst;
        exp_ill  = is_illegal(int'(chan_sel), int'(band_sel));
        exp_band = int'(band_sel);
        exp_live = 1;
    end

    always @(negedge clk) begin
        if (exp_live && !done) begin
            for (int m = 0; m < 3; m++) begin
                string tag;
                if (exp_rst) tag = "R12";
                else if (exp_ill) tag = (m == 0) ? "R8" : ((m == 1) ? "R9" : "R10");
                else tag = (exp_band == 2) ? "R1" : "R5";
                chk(tag, dut_word(m), exp_w[m]);
            end
        end
    end

    task automatic drive(int ch, int band);
        @(negedge clk);
        chan_sel = 6'(ch);
        band_sel = 3'(band);
    endtask

    task automatic code_after(int ch, int band, string req, int exp);
        drive(ch, band);
        @(negedge clk);
        chk(req, int'(nc_c9), exp);
    endtask

    initial begin
        for (int f = 26965; f <= 27405; f += 10)
            if (f != 26995 && f != 27045 && f != 27095 && f != 27145 && f != 27195)
                freqs.push_back(f);

        repeat (3) @(negedge clk);
        // R12 reset state on every variant
        chk("R12", dut_word(0), 1);
        chk("R12", dut_word(1), 1);
        chk("R12", dut_word(2), 1);
        rst = 1'b0;

        code_after(1, 2, "R1", 330);
        code_after(40, 2, "R1", 286);
        // R4 binary weights: 330 = 256+64+8+2
        chk("R4", int'(nc_c9[8] & nc_c9[6] & nc_c9[3] & nc_c9[1]) + 0, 0);
        code_after(1, 2, "R4", 330);
        chk("R4", int'({nc_c9[8], nc_c9[6], nc_c9[3], nc_c9[1]}), 4'hF);
        chk("R4", $countones(nc_c9), 4);
        code_after(23, 2, "R3", 301);
        code_after(24, 2, "R3", 303);
        code_after(25, 2, "R3", 302);
        code_after(1, 0, "R5", 420);
        code_after(40, 4, "R5", 196);
        code_after(10, 3, "R5", 319 - 45);

        // R2: walk the nominal band, no skipped code, never rising (R1)
        begin
            int prev_n = 1000;
            int bad = 0;
            for (int ch = 1; ch <= 40; ch++) begin
                int n;
                drive(ch, 2);
                @(negedge clk);
                n = int'(nc_c9);
                if (n == 327 || n == 322 || n == 317 || n == 312 || n == 307) bad++;
                if (ch != 24 && n > prev_n) bad++;
                prev_n = n;
            end
            chk("R2", bad, 0);
        end

        // R7 illegal selections, seen at the ports through the flags
        drive(0, 2);  @(negedge clk); chk("R7", int'(m_c9), 1);
        drive(41, 2); @(negedge clk); chk("R7", int'(m_c9), 1);
        drive(40, 5); @(negedge clk); chk("R7", int'(m_c9), 1);
        drive(40, 4); @(negedge clk); chk("R6", int'({v_c9, m_c9, i_c9}), 3'b100);
        drive(63, 7); @(negedge clk);
        chk("R8",  dut_word(0), 3);
        chk("R9",  int'(nc_c9), 320);
        chk("R10", int'(nc_c19), 308);

        // R11 one-clock latency
        drive(5, 2);
        @(negedge clk);
        chk("R11", int'(nc_c9), 325);
        @(negedge clk);
        chan_sel = 6'd6;
        #1;
        chk("R11", int'(nc_c9), 325);
        @(negedge clk);
        chk("R11", int'(nc_c9), 324);

        // full sweep, checked by the cycle model
        for (int b = 0; b < 8; b++)
            for (int ch = 0; ch < 64; ch++)
                drive(ch, b);

        // reset in mid-run
        drive(17, 1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        drive(33, 3);
        drive(0, 0);
        drive(12, 2);
        @(negedge clk);
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule